// File: doc/BRIEF.md
# Dual Multiply-Accumulate Unit

This block is the arithmetic core of a two-lane signal-processing datapath. Each cycle it can take one 32-bit X word and one 32-bit Y word. Each word packs two signed 16-bit operands. The two lanes multiply their operand pairs in parallel and fold the 32-bit products into their own 40-bit accumulators. The 8 guard bits above the product width absorb long runs of accumulation before the sum wraps.

The pipeline has two stages. The first stage registers the two products together with the operation and the valid flag. The second stage updates the accumulators and registers the results. A new operation can enter on every cycle. Operations issued back to back into the same accumulator see each other's results, with no stall. Four operations are selected by a 2-bit code:
- plain multiply, which reports the product but keeps the accumulator;
- accumulate;
- subtract;
- clear, which reloads the accumulator with the product.

Top module: `dual_mac_unit`

## Requirements
- R1: While `rst` is high and after it is released, `res_valid` is 0 and both result outputs are 0 until the first result appears.
- R2: Lane 0 multiplies `x_word[15:0]` by `y_word[15:0]` and drives `res0`. Lane 1 multiplies `x_word[31:16]` by `y_word[31:16]` and drives `res1`. All operands are signed two's complement.
- R3: Op code 2'b01 (accumulate) sets the lane accumulator to its old value plus the product sign-extended to 40 bits, and outputs the new value.
- R4: Op code 2'b10 (subtract) sets the lane accumulator to its old value minus the sign-extended product, and outputs the new value.
- R5: Op code 2'b11 (clear-load) sets the lane accumulator to the sign-extended product alone, ignoring the old value, and outputs it.
- R6: Op code 2'b00 (multiply) outputs the sign-extended product and leaves the accumulator unchanged for later operations.
- R7: Accumulator arithmetic wraps modulo 2^40 with no saturation.
- R8: `res_valid` is high exactly two cycles after the cycle in which `in_valid` was high. One operation is accepted every cycle, and back-to-back operations on the same accumulator produce correct running sums.
- R9: While `res_valid` is low, `res0` and `res1` hold their last values.
- R10: When `in_valid` is low, `in_op`, `x_word` and `y_word` have no effect on either accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| in_op | input | 2 | 00 multiply, 01 accumulate, 10 subtract, 11 clear-load |
| x_word | input | 32 | Packed X operands, lane 0 low half |
| y_word | input | 32 | Packed Y operands, lane 0 low half |
| res_valid | output | 1 | Results updated this cycle |
| res0 | output | 40 | Lane 0 result |
| res1 | output | 40 | Lane 1 result |

## Verification
On every cycle the assertions check four things: the two-cycle spacing between input valid and result valid, that the outputs hold while no result is issued, and that clear-load and plain-multiply results equal the signed product of the operands presented two cycles earlier. The behaviours that depend on accumulator history can only be shown by the bench scenarios, because the bench keeps its own running model. These are accumulate and subtract chains, the accumulator surviving a plain multiply, invalid cycles leaving state untouched, and the wrap past 2^40 after a long run of full-scale products.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_MAC = 2'b01,
    OP_MSU = 2'b10,
    OP_CLR = 2'b11
  } mac_op_e;
endpackage

// File: rtl/dmac_mul_lane.sv
module dmac_mul_lane #(
  parameter int OPW = 16,
  localparam int PRODW = 2 * OPW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  output logic [PRODW-1:0] prod
);
  logic signed [OPW-1:0]   sa;
  logic signed [OPW-1:0]   sb;
  logic signed [PRODW-1:0] p_d;

  assign sa = a;
  assign sb = b;

  always_comb begin
    p_d = sa * sb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod <= '0;
    end else if (en) begin
      prod <= p_d;
    end
  end
endmodule

// File: rtl/dmac_acc_lane.sv
module dmac_acc_lane
  import dmac_pkg::*;
#(
  parameter int PRODW = 32,
  parameter int ACCW  = 40,
  localparam int GUARD = ACCW - PRODW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  mac_op_e          op,
  input  logic [PRODW-1:0] prod,
  output logic [ACCW-1:0]  res
);
  logic [ACCW-1:0] acc_q;
  logic [ACCW-1:0] ext;
  logic [ACCW-1:0] acc_d;
  logic [ACCW-1:0] res_d;

  assign ext = {{GUARD{prod[PRODW-1]}}, prod};

  always_comb begin
    acc_d = acc_q;
    res_d = ext;
    case (op)
      OP_MAC: begin
        acc_d = acc_q + ext;
        res_d = acc_d;
      end
      OP_MSU: begin
        acc_d = acc_q - ext;
        res_d = acc_d;
      end
      OP_CLR: begin
        acc_d = ext;
        res_d = ext;
      end
      default: begin
        acc_d = acc_q;
        res_d = ext;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      res   <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      res   <= res_d;
    end
  end
endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit
  import dmac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  localparam int LANES = 2,
  localparam int WORDW = LANES * OPW,
  localparam int PRODW = 2 * OPW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [WORDW-1:0] x_word,
  input  logic [WORDW-1:0] y_word,
  output logic             res_valid,
  output logic [ACCW-1:0]  res0,
  output logic [ACCW-1:0]  res1
);
  logic            vld_a;
  mac_op_e         op_a;
  logic [PRODW-1:0] prod_a [LANES];
  logic [ACCW-1:0]  res_b  [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_a     <= 1'b0;
      op_a      <= OP_MUL;
      res_valid <= 1'b0;
    end else begin
      vld_a     <= in_valid;
      res_valid <= vld_a;
      if (in_valid) begin
        op_a <= mac_op_e'(in_op);
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dmac_mul_lane #(.OPW(OPW)) u_mul (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .a    (x_word[l*OPW +: OPW]),
      .b    (y_word[l*OPW +: OPW]),
      .prod (prod_a[l])
    );

    dmac_acc_lane #(.PRODW(PRODW), .ACCW(ACCW)) u_acc (
      .clk  (clk),
      .rst  (rst),
      .en   (vld_a),
      .op   (op_a),
      .prod (prod_a[l]),
      .res  (res_b[l])
    );
  end

  assign res0 = res_b[0];
  assign res1 = res_b[1];
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  localparam int WORDW = 2 * OPW,
  localparam int PRODW = 2 * OPW
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       in_op,
  input logic [WORDW-1:0] x_word,
  input logic [WORDW-1:0] y_word,
  input logic             res_valid,
  input logic [ACCW-1:0]  res0,
  input logic [ACCW-1:0]  res1
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd2) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  function automatic logic [ACCW-1:0] sx_prod(input logic [OPW-1:0] a,
                                               input logic [OPW-1:0] b);
    logic signed [PRODW-1:0] p;
    p = $signed(a) * $signed(b);
    return {{(ACCW-PRODW){p[PRODW-1]}}, p};
  endfunction

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (res_valid == $past(in_valid, 2))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res0) && $stable(res1))); // R9

  AST_CLR_LANE0: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && res_valid && $past(in_op, 2) == 2'b11)
      |-> (res0 == sx_prod($past(x_word[OPW-1:0], 2), $past(y_word[OPW-1:0], 2)))); // R5

  AST_CLR_LANE1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && res_valid && $past(in_op, 2) == 2'b11)
      |-> (res1 == sx_prod($past(x_word[WORDW-1:OPW], 2), $past(y_word[WORDW-1:OPW], 2)))); // R2

  AST_MUL_RESULT: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && res_valid && $past(in_op, 2) == 2'b00)
      |-> (res0 == sx_prod($past(x_word[OPW-1:0], 2), $past(y_word[OPW-1:0], 2))
        && res1 == sx_prod($past(x_word[WORDW-1:OPW], 2), $past(y_word[WORDW-1:OPW], 2)))); // R6
endmodule

bind dual_mac_unit dmac_checker #(.OPW(OPW), .ACCW(ACCW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .x_word    (x_word),
  .y_word    (y_word),
  .res_valid (res_valid),
  .res0      (res0),
  .res1      (res1)
);

// File: tb/dual_mac_unit_test.sv
module dual_mac_unit_test;
  typedef struct packed {
    logic [39:0] e0;
    logic [39:0] e1;
    logic [31:0] due;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] x_word = '0;
  logic [31:0] y_word = '0;
  logic        res_valid;
  logic [39:0] res0, res1;

  int unsigned checks = 0;
  int unsigned fails = 0;
  logic [31:0] cyc = 0;
  logic [39:0] m0 = '0, m1 = '0;
  logic [39:0] last0 = '0, last1 = '0;
  exp_t        sb[$];
  logic        done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_mac_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .x_word(x_word), .y_word(y_word),
    .res_valid(res_valid), .res0(res0), .res1(res1)
  );

  function automatic logic [39:0] sxp(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] p;
    p = $signed(a) * $signed(b);
    return {{8{p[31]}}, p};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // driver: presents one operation and pushes its expected results
  task automatic drive(input logic [1:0] op, input logic [31:0] x, input logic [31:0] y);
    logic [39:0] p0, p1;
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; in_op = op; x_word = x; y_word = y;
    p0 = sxp(x[15:0], y[15:0]);
    p1 = sxp(x[31:16], y[31:16]);
    case (op)
      2'b01: begin m0 = m0 + p0; m1 = m1 + p1; e.e0 = m0; e.e1 = m1; end
      2'b10: begin m0 = m0 - p0; m1 = m1 - p1; e.e0 = m0; e.e1 = m1; end
      2'b11: begin m0 = p0; m1 = p1; e.e0 = m0; e.e1 = m1; end
      default: begin e.e0 = p0; e.e1 = p1; end
    endcase
    e.due = cyc + 2;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_op = 2'b11;
      x_word = $urandom; y_word = $urandom;   // R10: must be ignored
    end
  endtask

  // monitor: compares results as the design produces them
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected valid", {39'd0, res_valid}, 40'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.due, "R8 latency", 40'(cyc), 40'(e.due));
          chk(res0 == e.e0, "R3/R4/R5/R6/R7 lane0", res0, e.e0);
          chk(res1 == e.e1, "R2 lane1", res1, e.e1);
        end
        last0 = res0; last1 = res1;
      end else begin
        if (sb.size() != 0 && sb[0].due <= cyc)
          chk(1'b0, "R8 missing valid", 40'(cyc), 40'(sb[0].due));
        chk(res0 == last0 && res1 == last1, "R9 hold", res0, last0);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid in reset", {39'd0, res_valid}, 40'd0);
    chk(res0 == 40'd0 && res1 == 40'd0, "R1 outputs in reset", res0, 40'd0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0 && res0 == 40'd0, "R1 after release", res0, 40'd0);

    // R2 lane mapping, signed operands
    drive(2'b11, 32'h0003_FFFE, 32'h0005_0007);
    idle(3);
    // R3 back-to-back accumulate (R8 running sums)
    drive(2'b01, 32'h0002_0004, 32'h0003_FFFF);
    drive(2'b01, 32'h7FFF_8000, 32'h7FFF_8000);
    drive(2'b01, 32'hFFF0_0010, 32'h0010_0010);
    // R4 subtract
    drive(2'b10, 32'h1234_8000, 32'h0100_7FFF);
    drive(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R6 multiply keeps accumulator; next accumulate continues the old sum
    drive(2'b00, 32'h0101_0202, 32'h0303_0404);
    drive(2'b01, 32'h0001_0001, 32'h0001_0001);
    // R10 invalid cycles with random operands do not disturb state
    idle(4);
    drive(2'b01, 32'h0000_0000, 32'h0000_0000);
    // R7 wrap: 1024 full-scale products of 2^30 reach 2^40 = 0
    drive(2'b11, 32'h8000_8000, 32'h8000_8000);
    for (int i = 0; i < 1023; i++) drive(2'b01, 32'h8000_8000, 32'h8000_8000);
    drive(2'b01, 32'h0000_0000, 32'h0000_0000);
    idle(2);
    drive(2'b01, 32'h8000_8000, 32'h8000_8000);
    // R7 downward wrap through zero
    drive(2'b11, 32'h0000_0000, 32'h0000_0000);
    drive(2'b10, 32'h8000_8000, 32'h8000_8000);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else drive(2'($urandom), $urandom, $urandom);
    end
    idle(5);
    chk(sb.size() == 0, "R8 all results delivered", 40'(sb.size()), 40'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired: actual %0d expected 0", sb.size());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule